// File: doc/BRIEF.md
# Split-Accumulator Despreading Correlator

This block correlates a stream of quantized chip samples against a spreading-code chip stream for direct-sequence spread-spectrum reception. Samples arrive in sign-magnitude form, one per accepted chip. The sample sign is combined with the current code chip to give an effective sign. That sign does not pass through any arithmetic. It only decides which of two unsigned accumulators receives the sample magnitude: the positive one or the negative one.

Each accumulator is a carry-save register pair. Within a symbol no carry travels from one bit to the next. When the last chip of a symbol window is accepted, the carry-save state of both accumulators is moved into hold registers and the working registers clear, so the next chip can start the following symbol in the very next cycle. One cycle later each hold pair is resolved to binary, the negative total is subtracted from the positive total, and the signed result is registered with a one-cycle strobe.

The block holds two identical lanes, one for in-phase and one for quadrature samples. Both lanes share the code chip and the symbol counter.

Top module: `despread_corr`

## Requirements
- R1: After reset, `res_valid` is 0 and both results read 0.
- R2: The effective sign is the sample sign bit XOR the code chip. A sign bit of 1 marks a negative sample, and a code chip of 1 multiplies the sample by -1. A sample with effective sign 0 adds its magnitude to the result, and one with effective sign 1 subtracts it.
- R3: Each result equals the signed sum of the effective-signed magnitudes of the CHIPS accepted samples of one window, as a two's-complement value of ACC_W+1 bits (10 bits by default).
- R4: `res_valid` is high for exactly one cycle. It rises on the second clock edge after the edge that accepts the last chip of a window.
- R5: A chip accepted on the edge right after a window's last chip is counted in the next window. No sample is lost or counted twice across a boundary.
- R6: In cycles where `chip_valid` is 0, the sample and code inputs have no effect on the chip count or on any sum.
- R7: A sample of magnitude 0 leaves both accumulators unchanged, whatever its sign.
- R8: The I and Q lanes are computed independently from their own samples with the shared code chip.
- R9: The full range of ±CHIPS×(2^MAG_W−1) (±448 by default) is produced without wrap-around.
- R10: Between strobes, both results hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_valid | input | 1 | Sample and code chip are accepted this cycle |
| code_chip | input | 1 | Combined spreading-code chip, 1 = multiply by -1 |
| i_sign | input | 1 | In-phase sample sign, 1 = negative |
| i_mag | input | MAG_W | In-phase sample magnitude |
| q_sign | input | 1 | Quadrature sample sign, 1 = negative |
| q_mag | input | MAG_W | Quadrature sample magnitude |
| res_valid | output | 1 | One-cycle strobe, new results present |
| res_i | output | ACC_W+1 | In-phase correlation, two's complement |
| res_q | output | ACC_W+1 | Quadrature correlation, two's complement |

## Verification
The bench uses the default parameters: 3-bit magnitudes, a 64-chip window and 9-bit accumulators. With these values the extreme results of ±448 can be reached with constant full-scale samples, which is where a carry-save vector that drops its top carry, or a result that is too narrow, would show up. Constant-sample windows with all-zero, all-one and alternating codes give fixed sums that can be worked out in advance. Pseudo-random windows with idle gaps, and windows sent back to back with no idle cycle, exercise the boundary handover and the I/Q independence.

// File: rtl/despread_pkg.sv
package despread_pkg;
  localparam int NUM_LANES = 2;
  localparam int LANE_I = 0;
  localparam int LANE_Q = 1;

  function automatic int acc_width(input int mag_w, input int chips);
    return $clog2(chips * ((1 << mag_w) - 1) + 1);
  endfunction
endpackage

// File: rtl/csa_accum.sv
module csa_accum #(
  parameter int MAG_W = 3,
  parameter int ACC_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             dump,
  input  logic [MAG_W-1:0] addend,
  output logic [ACC_W-1:0] hold_s,
  output logic [ACC_W-1:0] hold_c
);
  logic [ACC_W-1:0] s_q, c_q, a_ext, nxt_s, maj, nxt_c, tot;

  assign a_ext = {{(ACC_W-MAG_W){1'b0}}, addend};
  // 3:2 compression per bit, carries shift up one place and are never propagated
  assign nxt_s = s_q ^ c_q ^ a_ext;
  assign maj   = (s_q & c_q) | (s_q & a_ext) | (c_q & a_ext);
  assign nxt_c = {maj[ACC_W-2:0], 1'b0};
  assign tot   = s_q + c_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q    <= '0;
      c_q    <= '0;
      hold_s <= '0;
      hold_c <= '0;
    end else if (en) begin
      if (dump) begin
        hold_s <= nxt_s;
        hold_c <= nxt_c;
        s_q    <= '0;
        c_q    <= '0;
      end else begin
        s_q <= nxt_s;
        c_q <= nxt_c;
      end
    end
  end

  assert_zero_mag_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !dump && addend == '0) |=> $stable(tot));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(tot));
  assert_fresh_start_R5: assert property (@(posedge clk) disable iff (rst)
    (en && dump) |=> (tot == '0));
endmodule

// File: rtl/corr_lane.sv
module corr_lane #(
  parameter int MAG_W = 3,
  parameter int CHIPS = 64,
  parameter int ACC_W = 9,
  parameter int RES_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    chip_en,
  input  logic                    dump,
  input  logic                    load,
  input  logic                    smp_sign,
  input  logic [MAG_W-1:0]        smp_mag,
  input  logic                    code_chip,
  output logic signed [RES_W-1:0] res
);
  localparam int MAXV = CHIPS * ((1 << MAG_W) - 1);

  logic             eff_neg;
  logic [MAG_W-1:0] pos_add, neg_add;
  logic [ACC_W-1:0] ps, pc, ns, nc, pos_tot, neg_tot;

  assign eff_neg = smp_sign ^ code_chip;
  assign pos_add = eff_neg ? '0 : smp_mag;
  assign neg_add = eff_neg ? smp_mag : '0;

  csa_accum #(.MAG_W(MAG_W), .ACC_W(ACC_W)) u_pos (
    .clk(clk), .rst(rst), .en(chip_en), .dump(dump),
    .addend(pos_add), .hold_s(ps), .hold_c(pc));

  csa_accum #(.MAG_W(MAG_W), .ACC_W(ACC_W)) u_neg (
    .clk(clk), .rst(rst), .en(chip_en), .dump(dump),
    .addend(neg_add), .hold_s(ns), .hold_c(nc));

  assign pos_tot = ps + pc;
  assign neg_tot = ns + nc;

  always_ff @(posedge clk) begin
    if (rst) res <= '0;
    else if (load) res <= $signed({1'b0, pos_tot}) - $signed({1'b0, neg_tot});
  end

  assert_res_range_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (res <= MAXV && res >= -MAXV));
endmodule

// File: rtl/despread_corr.sv
module despread_corr
  import despread_pkg::*;
#(
  parameter int MAG_W = 3,
  parameter int CHIPS = 64,
  localparam int ACC_W = acc_width(MAG_W, CHIPS),
  localparam int RES_W = ACC_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    chip_valid,
  input  logic                    code_chip,
  input  logic                    i_sign,
  input  logic [MAG_W-1:0]        i_mag,
  input  logic                    q_sign,
  input  logic [MAG_W-1:0]        q_mag,
  output logic                    res_valid,
  output logic signed [RES_W-1:0] res_i,
  output logic signed [RES_W-1:0] res_q
);
  localparam int CNT_W = (CHIPS > 1) ? $clog2(CHIPS) : 1;

  logic [CNT_W-1:0] cnt;
  logic             last, dump_q;
  logic             sgn_v [NUM_LANES];
  logic [MAG_W-1:0] mag_v [NUM_LANES];
  logic signed [RES_W-1:0] res_v [NUM_LANES];

  assign last = (cnt == CNT_W'(CHIPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      dump_q    <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      if (chip_valid) cnt <= last ? '0 : cnt + CNT_W'(1);
      dump_q    <= chip_valid && last;
      res_valid <= dump_q;
    end
  end

  assign sgn_v[LANE_I] = i_sign;
  assign sgn_v[LANE_Q] = q_sign;
  assign mag_v[LANE_I] = i_mag;
  assign mag_v[LANE_Q] = q_mag;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    corr_lane #(.MAG_W(MAG_W), .CHIPS(CHIPS), .ACC_W(ACC_W), .RES_W(RES_W)) u_lane (
      .clk(clk), .rst(rst), .chip_en(chip_valid), .dump(last), .load(dump_q),
      .smp_sign(sgn_v[g]), .smp_mag(mag_v[g]), .code_chip(code_chip),
      .res(res_v[g]));
  end

  assign res_i = res_v[LANE_I];
  assign res_q = res_v[LANE_Q];

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  assert_valid_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (chip_valid && last) |=> ##1 res_valid);
  assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !chip_valid |=> $stable(cnt));
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(res_i) && $stable(res_q)));
endmodule

// File: tb/despread_corr_bench.sv
module despread_corr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAG_W = 3;
  localparam int CHIPS = 64;
  localparam int RES_W = 10;
  localparam int NVEC = 8;

  // fields: isgn, imag, qsgn, qmag, code mode (0 all 0, 1 all 1, 2 alternating), exp_i, exp_q
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b0, 3'd7, 1'b0, 3'd7, 2'd0,  10'sd448,  10'sd448},
    {1'b1, 3'd7, 1'b0, 3'd7, 2'd0, -10'sd448,  10'sd448},
    {1'b0, 3'd5, 1'b1, 3'd3, 2'd1, -10'sd320,  10'sd192},
    {1'b0, 3'd7, 1'b1, 3'd7, 2'd2,  10'sd0,    10'sd0},
    {1'b1, 3'd2, 1'b0, 3'd0, 2'd0, -10'sd128,  10'sd0},
    {1'b1, 3'd0, 1'b1, 3'd0, 2'd1,  10'sd0,    10'sd0},
    {1'b0, 3'd3, 1'b0, 3'd6, 2'd1, -10'sd192, -10'sd384},
    {1'b1, 3'd7, 1'b1, 3'd7, 2'd1,  10'sd448,  10'sd448}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_valid = 1'b0, code_chip = 1'b0, i_sign = 1'b0, q_sign = 1'b0;
  logic [MAG_W-1:0] i_mag = '0, q_mag = '0;
  logic res_valid;
  logic signed [RES_W-1:0] res_i, res_q;

  int checks = 0, errors = 0;
  int acc_i, acc_q;
  int cap_n = 0, cap_i [4], cap_q [4];
  logic prev_valid = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  despread_corr #(.MAG_W(MAG_W), .CHIPS(CHIPS)) u_despread_corr (
    .clk(clk), .rst(rst), .chip_valid(chip_valid), .code_chip(code_chip),
    .i_sign(i_sign), .i_mag(i_mag), .q_sign(q_sign), .q_mag(q_mag),
    .res_valid(res_valid), .res_i(res_i), .res_q(res_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // capture strobes, and flag a strobe longer than one cycle (R4)
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid && prev_valid) chk("R4 strobe width", 2, 1);
      if (res_valid && cap_n < 4) begin
        cap_i[cap_n] = int'(res_i);
        cap_q[cap_n] = int'(res_q);
        cap_n++;
      end
      prev_valid = res_valid;
    end
  end

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic send_chip(input logic is, input logic [MAG_W-1:0] im,
                           input logic qs, input logic [MAG_W-1:0] qm, input logic cc);
    i_sign = is; i_mag = im; q_sign = qs; q_mag = qm; code_chip = cc;
    chip_valid = 1'b1;
    acc_i += (is ^ cc) ? -int'(im) : int'(im);
    acc_q += (qs ^ cc) ? -int'(qm) : int'(qm);
    @(posedge clk);
    @(negedge clk);
    chip_valid = 1'b0;
  endtask

  task automatic idle_garbage(input int n);
    for (int k = 0; k < n; k++) begin
      lfsr = step(lfsr);
      {i_sign, i_mag, q_sign, q_mag, code_chip} = lfsr[8:0];
      chip_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic rand_symbol(input logic gaps);
    for (int k = 0; k < CHIPS; k++) begin
      if (gaps) begin
        lfsr = step(lfsr);
        if (lfsr[0] && lfsr[3]) idle_garbage(int'(lfsr[5:4]) + 1);
      end
      lfsr = step(lfsr);
      send_chip(lfsr[0], lfsr[3:1], lfsr[4], lfsr[7:5], lfsr[9]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", int'(res_valid), 0);
    chk("R1 res_i after reset", int'(res_i), 0);
    chk("R1 res_q after reset", int'(res_q), 0);

    // table of constant-sample windows (R2, R3, R7, R9)
    for (int v = 0; v < NVEC; v++) begin
      logic [29:0] e;
      int n0;
      e = VEC[v];
      n0 = cap_n;
      acc_i = 0; acc_q = 0;
      for (int k = 0; k < CHIPS; k++)
        send_chip(e[29], e[28:26], e[25], e[24:22],
                  (e[21:20] == 2'd1) ? 1'b1 : (e[21:20] == 2'd2) ? 1'(k % 2) : 1'b0);
      chk("R4 no strobe one cycle after last chip", int'(res_valid), 0);
      @(negedge clk);
      chk("R4 strobe two edges after last chip", int'(res_valid), 1);
      chk("R2 R3 R9 table res_i", int'(res_i), int'($signed(e[19:10])));
      chk("R2 R3 R9 R8 table res_q", int'(res_q), int'($signed(e[9:0])));
      @(negedge clk);
      chk("R4 strobe count", cap_n - n0, 1);
      cap_n = 0;
    end

    // random window with idle gaps and garbage inputs (R6, R3, R8)
    acc_i = 0; acc_q = 0;
    rand_symbol(1'b1);
    repeat (2) @(negedge clk);
    chk("R6 gaps res_i", cap_i[0], acc_i);
    chk("R6 R8 gaps res_q", cap_q[0], acc_q);
    idle_garbage(20);
    chk("R10 res_i held", int'(res_i), acc_i);
    chk("R10 res_q held", int'(res_q), acc_q);
    cap_n = 0;

    // three windows back to back, no idle between (R5)
    begin
      int ei [3], eq [3];
      for (int s = 0; s < 3; s++) begin
        acc_i = 0; acc_q = 0;
        rand_symbol(1'b0);
        ei[s] = acc_i; eq[s] = acc_q;
      end
      repeat (2) @(negedge clk);
      chk("R5 window count", cap_n, 3);
      for (int s = 0; s < 3; s++) begin
        chk("R5 back-to-back res_i", cap_i[s], ei[s]);
        chk("R5 back-to-back res_q", cap_q[s], eq[s]);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule